// File: doc/BRIEF.md
# Multiplexed ADC Channel Scan Sequencer

This block lets a converter with a few input channels read many analog signals. Each converter channel is fed by an external analog multiplexer with 2^SEL_W inputs. The block drives a shared multiplexer select bus and the converter channel index. It requests one conversion at a time. Every sample that comes back is tagged with a flat input number.

The scan is nested. All multiplexer inputs of one converter channel are read in order, and then the channel index moves on. After the last channel the scan wraps to the start and runs again without end. Each input is therefore sampled at the converter's peak rate divided by the number of inputs.

The select value moves forward as soon as acquisition of the current sample has finished, while the converter is still converting. The next multiplexer input thus has the whole conversion time to settle before it is acquired.

Top module: `adc_mux_scan`

## Requirements
- R1: While reset is high, `mux_sel` and `adc_ch` read 0 and `smp_valid` is low.
- R2: `start_conv` is high for exactly one cycle per conversion. It is not raised again until the conversion it started has returned its data, so at most one conversion is outstanding.
- R3: `mux_sel` and `adc_ch` keep their values from the request until the acquisition-done pulse is accepted.
- R4: In the cycle after an accepted `acq_done`, `mux_sel` has increased by one with `adc_ch` unchanged. If `mux_sel` was 2^SEL_W-1, it returns to 0 and `adc_ch` increases by one.
- R5: When `mux_sel` returns to 0 while `adc_ch` is NUM_CH-1, `adc_ch` wraps to 0 and the scan repeats.
- R6: In the cycle after an accepted `conv_done`, `smp_valid` is high for one cycle, and two outputs carry that sample:
  - `smp_data` holds the `adc_data` value present with `conv_done`.
  - `smp_idx` equals adc_ch*2^SEL_W + mux_sel, using the values of `adc_ch` and `mux_sel` when acquisition was accepted.
- R7: An `acq_done` that arrives while a conversion result is awaited is ignored: the select bus and the channel index do not change. A `conv_done` that arrives while acquisition is awaited is ignored: no sample is produced and no new request is made.
- R8: The default configuration is NUM_CH=4 and SEL_W=2. This gives 16 inputs, numbered 0 to 15, and a full scan period of 16 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_done | input | 1 | Pulse: the converter has finished acquiring, and conversion has begun |
| conv_done | input | 1 | Pulse: the conversion is complete and `adc_data` is valid |
| adc_data | input | DATA_W | Converter result word |
| start_conv | output | 1 | One-cycle request to start a conversion |
| mux_sel | output | SEL_W | Select bus shared by all external multiplexers |
| adc_ch | output | CH_W | Converter channel index |
| smp_valid | output | 1 | One-cycle strobe for a tagged sample |
| smp_idx | output | SEL_W+CH_W | Flat input number of the sample |
| smp_data | output | DATA_W | Sample word |

## Verification
The bench sweeps more than two full scans. It varies the gaps between the handshake pulses and checks, after every acquisition, the exact select value and channel index the counters should hold. Two kinds of wrong design are caught this way:
- A design that advanced the select at the request, not at acquisition, would show a changed select before `acq_done`.
- A design that mishandled the wrap at the last input or the last channel would tag the 16th sample with something other than 15, or fail to restart at 0.

Stray handshake pulses are injected in the wrong phase. A design that accepted them would advance the select twice, or emit a spurious sample and a second request.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        SCAN_REQ  = 2'd0,
        SCAN_ACQ  = 2'd1,
        SCAN_CONV = 2'd2
    } scan_state_e;

    // Flat input number: channel major, select minor.
    function automatic int unsigned flat_index(int unsigned ch, int unsigned sel,
                                               int unsigned sel_w);
        return (ch << sel_w) | sel;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic acq_done,
    input  logic conv_done,
    output logic start_conv,
    output logic advance,
    output logic capture
);
    scan_state_e state_q;

    assign start_conv = (state_q == SCAN_REQ);
    assign advance    = (state_q == SCAN_ACQ)  && acq_done;
    assign capture    = (state_q == SCAN_CONV) && conv_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_REQ;
        end else begin
            unique case (state_q)
                SCAN_REQ:  state_q <= SCAN_ACQ;
                SCAN_ACQ:  if (acq_done)  state_q <= SCAN_CONV;
                SCAN_CONV: if (conv_done) state_q <= SCAN_REQ;
                default:   state_q <= SCAN_REQ;
            endcase
        end
    end
endmodule

// File: rtl/scan_counter.sv
module scan_counter #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2,
    parameter int CH_W   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [SEL_W-1:0] sel,
    output logic [CH_W-1:0]  ch
);
    localparam logic [SEL_W-1:0] SEL_LAST = '1;
    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);

    logic sel_at_end;
    logic ch_at_end;

    assign sel_at_end = (sel == SEL_LAST);
    assign ch_at_end  = (ch == CH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
            ch  <= '0;
        end else if (advance) begin
            if (sel_at_end) begin
                sel <= '0;
                ch  <= ch_at_end ? '0 : ch + 1'b1;
            end else begin
                sel <= sel + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sample_tagger.sv
module sample_tagger
    import scan_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SEL_W  = 2,
    parameter int CH_W   = 2,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              capture,
    input  logic [SEL_W-1:0]  sel,
    input  logic [CH_W-1:0]   ch,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] data
);
    logic [IDX_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            valid <= 1'b0;
            idx   <= '0;
            data  <= '0;
        end else begin
            if (advance) begin
                tag_q <= IDX_W'(flat_index(int'(ch), int'(sel), SEL_W));
            end
            valid <= capture;
            if (capture) begin
                idx  <= tag_q;
                data <= din;
            end
        end
    end
endmodule

// File: rtl/adc_mux_scan.sv
module adc_mux_scan #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 12,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W = SEL_W + CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_done,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              start_conv,
    output logic [SEL_W-1:0]  mux_sel,
    output logic [CH_W-1:0]   adc_ch,
    output logic              smp_valid,
    output logic [IDX_W-1:0]  smp_idx,
    output logic [DATA_W-1:0] smp_data
);
    logic advance;
    logic capture;

    scan_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .acq_done   (acq_done),
        .conv_done  (conv_done),
        .start_conv (start_conv),
        .advance    (advance),
        .capture    (capture)
    );

    scan_counter #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .CH_W(CH_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .sel     (mux_sel),
        .ch      (adc_ch)
    );

    sample_tagger #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CH_W(CH_W), .IDX_W(IDX_W)) u_tag (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .capture (capture),
        .sel     (mux_sel),
        .ch      (adc_ch),
        .din     (adc_data),
        .valid   (smp_valid),
        .idx     (smp_idx),
        .data    (smp_data)
    );
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2,
    parameter int CH_W   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             start_conv,
    input logic             acq_done,
    input logic             conv_done,
    input logic [SEL_W-1:0] mux_sel,
    input logic [CH_W-1:0]  adc_ch,
    input logic             smp_valid
);
    localparam logic [SEL_W-1:0] SEL_MAX = '1;
    localparam logic [CH_W-1:0]  CH_MAX  = CH_W'(NUM_CH - 1);

    logic acq_wait;   // a request is out and acquisition not yet seen
    logic pending;    // a request is out and its sample not yet delivered

    always_ff @(posedge clk) begin
        if (rst) begin
            acq_wait <= 1'b0;
            pending  <= 1'b0;
        end else begin
            if (start_conv)    acq_wait <= 1'b1;
            else if (acq_done) acq_wait <= 1'b0;
            if (start_conv)     pending <= 1'b1;
            else if (smp_valid) pending <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            assert_reset_values_R1: assert (mux_sel == '0 || $past(rst) == 1'b0)
                else $error("select not cleared by reset");
        end
    end

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        start_conv |=> !start_conv);

    assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
        start_conv |-> (!pending || smp_valid));

    assert_hold_until_acq_R3: assert property (@(posedge clk) disable iff (rst)
        !acq_done |=> ($stable(mux_sel) && $stable(adc_ch)));

    assert_sel_step_R4: assert property (@(posedge clk) disable iff (rst)
        (acq_wait && acq_done && mux_sel != SEL_MAX)
            |=> (mux_sel == $past(mux_sel) + 1'b1) && $stable(adc_ch));

    assert_ch_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (acq_wait && acq_done && mux_sel == SEL_MAX && adc_ch == CH_MAX)
            |=> (mux_sel == '0) && (adc_ch == '0));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    assert_valid_cause_R6: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(conv_done));
endmodule

bind adc_mux_scan scan_checker #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_conv (start_conv),
    .acq_done   (acq_done),
    .conv_done  (conv_done),
    .mux_sel    (mux_sel),
    .adc_ch     (adc_ch),
    .smp_valid  (smp_valid)
);

// File: tb/tb_adc_mux_scan.sv
`timescale 1ns/1ps
module tb_adc_mux_scan;
    localparam int NCH   = 4;
    localparam int NSEL  = 2;
    localparam int DW    = 12;
    localparam int NIN   = NCH << NSEL;
    localparam int NSAMP = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acq_done = 1'b0;
    logic conv_done = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic start_conv;
    logic [NSEL-1:0] mux_sel;
    logic [1:0] adc_ch;
    logic smp_valid;
    logic [3:0] smp_idx;
    logic [DW-1:0] smp_data;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    adc_mux_scan #(.NUM_CH(NCH), .SEL_W(NSEL), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .acq_done(acq_done), .conv_done(conv_done),
        .adc_data(adc_data), .start_conv(start_conv), .mux_sel(mux_sel),
        .adc_ch(adc_ch), .smp_valid(smp_valid), .smp_idx(smp_idx),
        .smp_data(smp_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        int exp_sel = 0;
        int exp_ch  = 0;
        int tag;
        int val;

        repeat (3) @(negedge clk);
        check(mux_sel == 0, "R1", "reset select", int'(mux_sel), 0);
        check(adc_ch == 0, "R1", "reset channel", int'(adc_ch), 0);
        check(smp_valid == 0, "R1", "reset valid", int'(smp_valid), 0);
        rst = 1'b0;

        for (int i = 0; i < NSAMP; i++) begin
            check(start_conv == 1, "R2", "request raised", int'(start_conv), 1);
            @(negedge clk);
            check(start_conv == 0, "R2", "request one cycle", int'(start_conv), 0);
            check(smp_valid == 0, "R6", "valid one cycle", int'(smp_valid), 0);
            repeat (i % 3) @(negedge clk);
            if (i % 7 == 3) begin
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
                check(smp_valid == 0, "R7", "stray conv_done sample", int'(smp_valid), 0);
                check(start_conv == 0, "R7", "stray conv_done request", int'(start_conv), 0);
            end
            check(int'(mux_sel) == exp_sel, "R3", "select before acq", int'(mux_sel), exp_sel);
            check(int'(adc_ch) == exp_ch, "R3", "channel before acq", int'(adc_ch), exp_ch);

            acq_done = 1'b1;
            @(negedge clk);
            acq_done = 1'b0;
            tag = exp_ch * (1 << NSEL) + exp_sel;
            if (exp_sel == (1 << NSEL) - 1) begin
                exp_sel = 0;
                exp_ch  = (exp_ch == NCH - 1) ? 0 : exp_ch + 1;
                check(int'(mux_sel) == exp_sel, "R4", "select wrap", int'(mux_sel), exp_sel);
                check(int'(adc_ch) == exp_ch, (exp_ch == 0) ? "R5" : "R4",
                      "channel step", int'(adc_ch), exp_ch);
            end else begin
                exp_sel++;
                check(int'(mux_sel) == exp_sel, "R4", "select step", int'(mux_sel), exp_sel);
                check(int'(adc_ch) == exp_ch, "R4", "channel held", int'(adc_ch), exp_ch);
            end

            for (int k = 0; k < (i * 5) % 4; k++) begin
                @(negedge clk);
                check(start_conv == 0, "R2", "no request while converting",
                      int'(start_conv), 0);
            end
            if (i % 5 == 2) begin
                acq_done = 1'b1;
                @(negedge clk);
                acq_done = 1'b0;
                check(int'(mux_sel) == exp_sel, "R7", "stray acq_done select",
                      int'(mux_sel), exp_sel);
                check(int'(adc_ch) == exp_ch, "R7", "stray acq_done channel",
                      int'(adc_ch), exp_ch);
            end

            val = (i * 173 + 5) & ((1 << DW) - 1);
            adc_data  = DW'(val);
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
            adc_data  = '0;
            check(smp_valid == 1, "R6", "sample strobe", int'(smp_valid), 1);
            check(int'(smp_idx) == tag, "R6", "sample index", int'(smp_idx), tag);
            check(int'(smp_data) == val, "R6", "sample data", int'(smp_data), val);
            if (i % NIN == NIN - 1)
                check(int'(smp_idx) == NIN - 1, "R8", "last input of scan",
                      int'(smp_idx), NIN - 1);
            if (i == NIN)
                check(int'(smp_idx) == 0, "R8", "scan period restart", int'(smp_idx), 0);
        end
        finish_run();
    end
endmodule